// File: doc/BRIEF.md
# CEC Bit Timing Receiver

This block turns the single-wire consumer-electronics control bus into decoded bytes. A slow tick of 32768 Hz, about 33 ticks per millisecond, drives one period counter. The counter restarts on every falling edge of the synchronised line. A start bit is judged on its low length and its full period. Each data bit is judged on its low length, its full period and its high length. The bit's value is the line level at a programmable sample tick after the falling edge.

Ten bits follow each start bit. The first eight are data, sent most significant bit first. The ninth is the end-of-message flag and the tenth is the acknowledge bit. Each completed ten-bit group gives a one-cycle strobe that carries the data, both flag bits, a marker for the header byte and an address-match result. Any timing violation gives a one-cycle error pulse and drops the frame. Every window is an input port, so the limits can be changed for a slower or faster bus. The line must have a pull-up and the tick must be one clock wide.

Top module: `cec_bit_rx`

## Requirements
- R1: After reset, byte_vld, err_pulse, addr_hit and byte_data are all 0, and the receiver waits for a falling edge.
- R2: A start bit's low length in ticks must lie in [st_low_min, st_low_max]. A shorter low gives an error at the rising edge. A low that exceeds st_low_max gives an error while the line is still low.
- R3: A start bit's period (falling edge to next falling edge) must lie in [st_per_min, st_per_max]. A high phase that carries the count past st_per_max gives an error before the next falling edge.
- R4: A data bit's value is the synchronised line level at the tick where the count since the falling edge reaches smp_pt. The line is high there (1) if it rose after fewer than smp_pt ticks, and low there (0) otherwise.
- R5: A data bit's low length must lie in [one_low_min, one_low_max] or in [zero_low_min, zero_low_max]. Any other length gives an error at the rising edge.
- R6: A data-bit low phase that exceeds low_err ticks gives an error while the line is still low.
- R7: A data bit whose period is shorter than per_min ticks gives an error at the falling edge that ends it.
- R8: A high phase longer than high_max ticks ends the frame. After the tenth bit of a group this gives the byte strobe. After any earlier bit it gives an error and no strobe.
- R9: Each strobe carries the data byte (first received bit in byte_data[7]), the ninth bit in byte_eom and the tenth bit in byte_ack. byte_first is 1 only on the first byte after a start bit.
- R10: After an error, no strobe appears until a valid start bit has been seen. A falling edge at which a period error is reported is itself taken as the possible start of a new start bit.
- R11: After a byte with byte_eom = 1 is completed by a falling edge, that edge begins a start bit and not a data bit.
- R12: addr_hit is 1 with the strobe of a frame's first byte only when la_cfg[4] (valid) is 1 and byte_data[3:0] equals la_cfg[3:0]. When la_cfg[4] is 0, addr_hit is never 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at the bus time base (32768 Hz) |
| line_in | input | 1 | Raw bus level, asynchronous |
| st_low_min | input | CW | Start bit minimum low, ticks |
| st_low_max | input | CW | Start bit maximum low, ticks |
| st_per_min | input | CW | Start bit minimum period, ticks |
| st_per_max | input | CW | Start bit maximum period, ticks |
| one_low_min | input | CW | Logic-1 minimum low, ticks |
| one_low_max | input | CW | Logic-1 maximum low, ticks |
| zero_low_min | input | CW | Logic-0 minimum low, ticks |
| zero_low_max | input | CW | Logic-0 maximum low, ticks |
| per_min | input | CW | Data bit minimum period, ticks |
| high_max | input | CW | High length that ends a frame, ticks |
| low_err | input | CW | Data low length that is an error, ticks |
| smp_pt | input | CW | Sample tick after the falling edge |
| la_cfg | input | 5 | [4] valid, [3:0] own logical address |
| byte_vld | output | 1 | One-cycle byte strobe |
| byte_data | output | 8 | Received data byte |
| byte_eom | output | 1 | End-of-message bit of the byte |
| byte_ack | output | 1 | Acknowledge bit of the byte |
| byte_first | output | 1 | Byte is the header of its frame |
| addr_hit | output | 1 | Header destination matches own address |
| err_pulse | output | 1 | One-cycle timing error pulse |

## Verification
The hardest case to reach from the ports is an error reported on a falling edge, where that same edge must then start a new start bit. This happens after a start period that is too short, after a data period that is too short, and after a byte that ends with its end-of-message bit set. The bench drives the line in whole tick counts, each change placed just after a tick, so every measured length is exact. It then sends a start bit directly after the faulty or final edge, with no idle gap, and expects a byte with the header marker. Each window limit is hit at its exact boundary value and one tick past it. The sample point is moved across a fixed low length, which shows that the bit value follows smp_pt and not the window that the low length falls in.

// File: rtl/cec_bit_rx.sv
module cec_bit_rx #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line_in,
  input  logic [CW-1:0] st_low_min,
  input  logic [CW-1:0] st_low_max,
  input  logic [CW-1:0] st_per_min,
  input  logic [CW-1:0] st_per_max,
  input  logic [CW-1:0] one_low_min,
  input  logic [CW-1:0] one_low_max,
  input  logic [CW-1:0] zero_low_min,
  input  logic [CW-1:0] zero_low_max,
  input  logic [CW-1:0] per_min,
  input  logic [CW-1:0] high_max,
  input  logic [CW-1:0] low_err,
  input  logic [CW-1:0] smp_pt,
  input  logic [4:0]    la_cfg,
  output logic          byte_vld,
  output logic [7:0]    byte_data,
  output logic          byte_eom,
  output logic          byte_ack,
  output logic          byte_first,
  output logic          addr_hit,
  output logic          err_pulse
);
  localparam int NBITS = 10;
  localparam int BW = $clog2(NBITS);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  typedef enum logic [2:0] {IDLE, SLO, SHI, BLO, BHI} st_t;

  st_t st;
  logic [2:0] sync;
  logic [CW-1:0] cnt, lowlen;
  logic [NBITS-1:0] shreg;
  logic [BW-1:0] bidx;
  logic bval, first_f;

  wire fall = sync[2] & ~sync[1];
  wire rise = ~sync[2] & sync[1];
  wire lvl = sync[1];
  wire [CW-1:0] hi_len = cnt - lowlen;
  wire in_one = (cnt >= one_low_min) && (cnt <= one_low_max);
  wire in_zero = (cnt >= zero_low_min) && (cnt <= zero_low_max);
  wire start_lo_ok = (cnt >= st_low_min) && (cnt <= st_low_max);
  wire start_per_ok = (cnt >= st_per_min) && (cnt <= st_per_max);
  wire last_bit = (bidx == BW'(NBITS - 1));
  wire [NBITS-1:0] nbits = {shreg[NBITS-2:0], bval};
  wire in_bit = (st == BLO) || (st == BHI);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '1;
    else sync <= {sync[1:0], line_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (fall) cnt <= '0;
    else if (tick && cnt != CMAX) cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bval <= 1'b0;
    else if (tick && in_bit && (CW'(cnt + 1'b1) == smp_pt)) bval <= lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      lowlen <= '0;
      shreg <= '0;
      bidx <= '0;
      first_f <= 1'b0;
      byte_vld <= 1'b0;
      byte_data <= '0;
      byte_eom <= 1'b0;
      byte_ack <= 1'b0;
      byte_first <= 1'b0;
      addr_hit <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      addr_hit <= 1'b0;
      err_pulse <= 1'b0;
      case (st)
        IDLE: if (fall) st <= SLO;
        SLO: begin
          if (rise) begin
            if (start_lo_ok) st <= SHI;
            else begin
              err_pulse <= 1'b1;
              st <= IDLE;
            end
          end else if (cnt > st_low_max) begin
            err_pulse <= 1'b1;
            st <= IDLE;
          end
        end
        SHI: begin
          if (fall) begin
            if (start_per_ok) begin
              st <= BLO;
              bidx <= '0;
              first_f <= 1'b1;
            end else begin
              err_pulse <= 1'b1;
              st <= SLO;
            end
          end else if (cnt > st_per_max) begin
            err_pulse <= 1'b1;
            st <= IDLE;
          end
        end
        BLO: begin
          if (rise) begin
            if (in_one || in_zero) begin
              lowlen <= cnt;
              st <= BHI;
            end else begin
              err_pulse <= 1'b1;
              st <= IDLE;
            end
          end else if (cnt > low_err) begin
            err_pulse <= 1'b1;
            st <= IDLE;
          end
        end
        BHI: begin
          if (fall) begin
            if (cnt < per_min) begin
              err_pulse <= 1'b1;
              st <= SLO;
            end else begin
              shreg <= nbits;
              if (last_bit) begin
                byte_vld <= 1'b1;
                byte_data <= nbits[9:2];
                byte_eom <= nbits[1];
                byte_ack <= nbits[0];
                byte_first <= first_f;
                addr_hit <= first_f && la_cfg[4] && (nbits[5:2] == la_cfg[3:0]);
                first_f <= 1'b0;
                bidx <= '0;
                st <= nbits[1] ? SLO : BLO;
              end else begin
                bidx <= bidx + 1'b1;
                st <= BLO;
              end
            end
          end else if (hi_len > high_max) begin
            st <= IDLE;
            if (last_bit) begin
              byte_vld <= 1'b1;
              byte_data <= nbits[9:2];
              byte_eom <= nbits[1];
              byte_ack <= nbits[0];
              byte_first <= first_f;
              addr_hit <= first_f && la_cfg[4] && (nbits[5:2] == la_cfg[3:0]);
              first_f <= 1'b0;
            end else begin
              err_pulse <= 1'b1;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r9_strobe_from_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(st == BHI));

  a_r12_hit_on_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> (byte_vld && byte_first));

  a_r10_err_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(st != IDLE));

  a_r11_eom_starts_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_eom && $past(fall)) |-> (st == SLO));

  a_r2_data_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == BLO) && $past(st != BLO)) |-> $past(st == SHI || st == BHI));
endmodule

// File: tb/cec_bit_rx_bench.sv
module cec_bit_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0, line_in = 1'b1;
  logic [1:0] tdiv = 2'd1;
  logic [9:0] st_low_min = 10'd115, st_low_max = 10'd128;
  logic [9:0] st_per_min = 10'd141, st_per_max = 10'd154;
  logic [9:0] one_low_min = 10'd13, one_low_max = 10'd26;
  logic [9:0] zero_low_min = 10'd43, zero_low_max = 10'd56;
  logic [9:0] per_min = 10'd67, high_max = 10'd92, low_err = 10'd111, smp_pt = 10'd34;
  logic [4:0] la_cfg = 5'h00;
  logic byte_vld, byte_eom, byte_ack, byte_first, addr_hit, err_pulse;
  logic [7:0] byte_data;
  wire tick = (tdiv == 2'd0);

  typedef struct packed {
    logic is_err;
    logic [7:0] d;
    logic eom, ack, first, hit;
  } ev_t;
  ev_t exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  cec_bit_rx u_cec_bit_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .st_low_min(st_low_min), .st_low_max(st_low_max),
    .st_per_min(st_per_min), .st_per_max(st_per_max),
    .one_low_min(one_low_min), .one_low_max(one_low_max),
    .zero_low_min(zero_low_min), .zero_low_max(zero_low_max),
    .per_min(per_min), .high_max(high_max), .low_err(low_err), .smp_pt(smp_pt),
    .la_cfg(la_cfg), .byte_vld(byte_vld), .byte_data(byte_data), .byte_eom(byte_eom),
    .byte_ack(byte_ack), .byte_first(byte_first), .addr_hit(addr_hit), .err_pulse(err_pulse)
  );

  always #4 clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 2'd1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not end (actual hung, expected finish)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (byte_vld || err_pulse)) begin
      checks = checks + 1;
      if (exp_q.size() == 0) begin
        fails = fails + 1;
        $display("FAIL R10 unexpected event: actual vld=%0b err=%0b data=%02h, expected none",
                 byte_vld, err_pulse, byte_data);
      end else begin
        automatic ev_t e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic ev_t a = '{is_err: err_pulse, d: byte_data, eom: byte_eom,
                             ack: byte_ack, first: byte_first, hit: addr_hit};
        if (e.is_err) begin
          if (!err_pulse || byte_vld) begin
            fails = fails + 1;
            $display("FAIL %s: actual vld=%0b err=%0b, expected error pulse", t, byte_vld, err_pulse);
          end
        end else if (a != e) begin
          fails = fails + 1;
          $display("FAIL %s: actual err=%0b d=%02h eom=%0b ack=%0b first=%0b hit=%0b, expected d=%02h eom=%0b ack=%0b first=%0b hit=%0b",
                   t, a.is_err, a.d, a.eom, a.ack, a.first, a.hit, e.d, e.eom, e.ack, e.first, e.hit);
        end
      end
    end
  end

  task automatic exp_byte(input logic [7:0] d, input logic eom, input logic ack,
                          input logic first, input logic hit, input string t);
    exp_q.push_back('{is_err: 1'b0, d: d, eom: eom, ack: ack, first: first, hit: hit});
    tag_q.push_back(t);
  endtask

  task automatic exp_err(input string t);
    exp_q.push_back('{is_err: 1'b1, d: 8'h00, eom: 1'b0, ack: 1'b0, first: 1'b0, hit: 1'b0});
    tag_q.push_back(t);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  task automatic drive(input logic v, input int n);
    @(negedge clk);
    line_in = v;
    wait_ticks(n);
  endtask

  task automatic start_bit(input int lo, input int hi);
    drive(1'b0, lo);
    drive(1'b1, hi);
  endtask

  task automatic send_bit(input logic b, input logic fin);
    automatic int lo = b ? 20 : 49;
    drive(1'b0, lo);
    drive(1'b1, fin ? 120 : 79 - lo);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic eom, input logic ack, input logic fin);
    for (int i = 7; i >= 0; i--) send_bit(d[i], 1'b0);
    send_bit(eom, 1'b0);
    send_bit(ack, fin);
  endtask

  task automatic settle();
    wait_ticks(20);
  endtask

  initial begin
    wait_ticks(3);
    @(negedge clk);
    checks = checks + 1;
    if (byte_vld || err_pulse || addr_hit || byte_data != 8'h00) begin
      fails = fails + 1;
      $display("FAIL R1 reset: actual vld=%0b err=%0b hit=%0b data=%02h, expected all 0",
               byte_vld, err_pulse, addr_hit, byte_data);
    end
    rst_n = 1'b1;
    wait_ticks(2);

    // R9 R12: two-byte frame, header matches valid address
    la_cfg = 5'h11;
    exp_byte(8'h41, 1'b0, 1'b1, 1'b1, 1'b1, "R9_header");
    exp_byte(8'h36, 1'b1, 1'b0, 1'b0, 1'b0, "R8_frame_end");
    start_bit(121, 26);
    send_byte(8'h41, 1'b0, 1'b1, 1'b0);
    send_byte(8'h36, 1'b1, 1'b0, 1'b1);

    // R12: valid bit clear, then address mismatch, then match on 0xF
    la_cfg = 5'h01;
    exp_byte(8'h41, 1'b1, 1'b0, 1'b1, 1'b0, "R12_invalid");
    start_bit(121, 26);
    send_byte(8'h41, 1'b1, 1'b0, 1'b1);
    la_cfg = 5'h13;
    exp_byte(8'h41, 1'b1, 1'b1, 1'b1, 1'b0, "R12_mismatch");
    start_bit(121, 26);
    send_byte(8'h41, 1'b1, 1'b1, 1'b1);
    la_cfg = 5'h1F;
    exp_byte(8'h4F, 1'b1, 1'b0, 1'b1, 1'b1, "R12_match");
    start_bit(121, 26);
    send_byte(8'h4F, 1'b1, 1'b0, 1'b1);

    // R5 R3 R7: window boundaries (start low 128, period 154; lows 13/26/43/56; period 67)
    la_cfg = 5'h15;
    exp_byte(8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, "R5_bounds");
    start_bit(128, 26);
    drive(1'b0, 13); drive(1'b1, 54);
    drive(1'b0, 56); drive(1'b1, 30);
    drive(1'b0, 26); drive(1'b1, 53);
    drive(1'b0, 43); drive(1'b1, 36);
    send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b1);
    la_cfg = 5'h10;
    exp_byte(8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R3_min_bounds");
    start_bit(115, 26);
    send_byte(8'h00, 1'b1, 1'b0, 1'b1);

    // R4: value follows the sample point for a fixed low of 43 ticks
    la_cfg = 5'h00;
    smp_pt = 10'd44;
    exp_byte(8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, "R4_sample_after");
    start_bit(121, 26);
    for (int i = 0; i < 10; i++) begin
      drive(1'b0, 43);
      drive(1'b1, (i == 9) ? 120 : 36);
    end
    smp_pt = 10'd43;
    exp_byte(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R4_sample_at");
    start_bit(121, 26);
    for (int i = 0; i < 10; i++) begin
      drive(1'b0, 43);
      drive(1'b1, (i == 9) ? 120 : 36);
    end
    smp_pt = 10'd34;

    // R2: start low too short, then too long
    exp_err("R2_short");
    start_bit(114, 60);
    exp_err("R2_long");
    drive(1'b0, 140);
    drive(1'b1, 60);
    exp_byte(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, "R10_recover");
    start_bit(121, 26);
    send_byte(8'h5A, 1'b1, 1'b0, 1'b1);

    // R3 R10: period too short, the faulting edge starts the next start bit
    exp_err("R3_per_short");
    exp_byte(8'hC3, 1'b1, 1'b1, 1'b1, 1'b0, "R10_edge_restart");
    start_bit(121, 19);
    start_bit(121, 26);
    send_byte(8'hC3, 1'b1, 1'b1, 1'b1);
    exp_err("R3_per_long");
    start_bit(121, 40);
    settle();

    // R5: data lows outside both windows
    exp_err("R5_gap");
    start_bit(121, 26);
    drive(1'b0, 30); drive(1'b1, 120);
    exp_err("R5_below");
    start_bit(121, 26);
    drive(1'b0, 12); drive(1'b1, 120);
    exp_err("R5_above");
    start_bit(121, 26);
    drive(1'b0, 57); drive(1'b1, 120);

    // R7 R10: data period too short, then a start bit from that edge
    exp_err("R7_per_short");
    exp_byte(8'h99, 1'b1, 1'b0, 1'b1, 1'b0, "R10_after_r7");
    start_bit(121, 26);
    drive(1'b0, 20); drive(1'b1, 46);
    start_bit(121, 26);
    send_byte(8'h99, 1'b1, 1'b0, 1'b1);

    // R6: data low beyond the error limit
    exp_err("R6_low_err");
    start_bit(121, 26);
    drive(1'b0, 112); drive(1'b1, 120);

    // R8: frame ends by high timeout before the tenth bit
    exp_err("R8_truncated");
    start_bit(121, 26);
    for (int i = 0; i < 5; i++) send_bit(i[0], i == 4);

    // R11: end-of-message byte followed at once by a new start bit
    la_cfg = 5'h12;
    exp_byte(8'h42, 1'b1, 1'b0, 1'b1, 1'b1, "R11_eom_byte");
    exp_byte(8'h12, 1'b1, 1'b1, 1'b1, 1'b1, "R11_next_frame");
    start_bit(121, 26);
    send_byte(8'h42, 1'b1, 1'b0, 1'b0);
    start_bit(121, 26);
    send_byte(8'h12, 1'b1, 1'b1, 1'b1);

    settle();
    checks = checks + 1;
    if (exp_q.size() != 0) begin
      fails = fails + 1;
      $display("FAIL R9 missing events: actual %0d pending, expected 0 (next %s)",
               exp_q.size(), tag_q[0]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule